// File: doc/BRIEF.md
# Coalescing Write Buffer with Burst Builder

This block sits between a write-through data cache and a bus initiator. Each word write from the processor side is stored with its address, data and byte-lane mask in an eight-entry first-in first-out store. The buffer then drains its contents as write bursts. Neighbouring entries whose addresses rise by exactly one word are merged into one burst, and the final beat of each burst carries an end-of-packet flag. A burst may be as short as one beat or as long as the whole buffer.

Only one bus transaction is open at any time. After the last beat of a burst has been accepted, the buffer stays silent until the response for that burst comes back. Entries stay in the buffer until that response arrives and are freed only then. The full flag tells the cache to stall the processor. The empty flag tells the cache when it may let a read pass, because the flag counts writes that are still in flight. If a response reports an error, the block raises a one-cycle error pulse toward the processor.

A burst does not start in a cycle where a write is being accepted. While the processor streams writes back to back, the buffer keeps collecting them so that longer runs can merge. It also starts at once when the buffer is full.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset, buf_empty is 1 and wr_full, cmd_valid and wr_err are 0.
- R2: A write is stored when wr_valid is 1 and wr_full is 0 at a rising edge. Stored writes leave as command beats in the order they were written, and each beat carries the stored address and data.
- R3: wr_full is 1 exactly while eight entries are held. A write offered while wr_full is 1 is dropped and never appears on the command side.
- R4: cmd_eop is 1 on a beat when the next stored entry's address is not this beat's address plus 4, or when that entry is the last one that was held when the burst began. A burst never has more beats than entries.
- R5: The 4-bit byte-lane mask (bit n enables byte n) travels with each entry to cmd_be. Partial masks do not stop two contiguous entries from merging into one burst.
- R6: A burst begins, with cmd_valid rising, one cycle after the first edge at which the buffer is non-empty and no write is accepted. cmd_valid stays 0 while writes are being accepted from an idle buffer.
- R7: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_addr, cmd_data, cmd_be and cmd_eop hold their values.
- R8: After a beat with cmd_eop is accepted, cmd_valid stays 0 until rsp_valid has been seen.
- R9: Entries are released only when the response for their burst is accepted. Until then they count toward wr_full and keep buf_empty at 0.
- R10: A response with rsp_err set produces a one-cycle pulse on wr_err in the cycle after the response is accepted.
- R11: rsp_valid is ignored while no burst is awaiting its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor write request |
| wr_addr | input | 32 | Word-aligned write address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_full | output | 1 | Buffer holds eight entries; stall the processor |
| buf_empty | output | 1 | No entry is held, including entries in flight |
| cmd_valid | output | 1 | Command beat present |
| cmd_ready | input | 1 | Bus accepts the command beat |
| cmd_addr | output | 32 | Beat address |
| cmd_data | output | 32 | Beat data |
| cmd_be | output | 4 | Beat byte enables |
| cmd_eop | output | 1 | Last beat of the burst |
| rsp_valid | input | 1 | Write response for the open burst |
| rsp_err | input | 1 | Response reports an error |
| wr_err | output | 1 | One-cycle error pulse to the processor |

## Verification
The hardest case to reach is a full buffer whose contents split into several bursts of different lengths, with a write offered while the buffer is full. The bench reaches it by holding cmd_ready low while it fills all eight slots with three contiguous runs. It then offers a ninth write and only afterwards opens the bus. Each response is delayed by two cycles, so the bench can watch the silent wait after each burst and see that the held entries still keep wr_full and buf_empty unchanged.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;
  localparam int WORD_BYTES = DW / 8;

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [BEW-1:0] be;
  } wentry_t;

  // Address of the word that directly follows a.
  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  // True when nxt continues a run that ends at prev.
  function automatic logic joins(input logic [AW-1:0] prev, input logic [AW-1:0] nxt);
    return nxt == next_word(prev);
  endfunction
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  wentry_t       push_ent,
  input  logic          free,
  input  logic [CW-1:0] free_cnt,
  input  logic [PW-1:0] rd_off,
  output wentry_t       cur_ent,
  output wentry_t       nxt_ent,
  output logic [CW-1:0] count
);
  wentry_t       mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] cur_idx, nxt_idx;

  assign cur_idx = head_q + rd_off;
  assign nxt_idx = cur_idx + PW'(1);
  assign cur_ent = mem[cur_idx];
  assign nxt_ent = mem[nxt_idx];
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (push) mem[tail_q] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + PW'(1);
      if (free) head_q <= head_q + PW'(free_cnt);
      count_q <= count_q + CW'(push) - (free ? free_cnt : CW'(0));
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !free) |-> (count_q < CW'(DEPTH)));

  // R9
  free_only_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q < $past(count_q)) |-> $past(free));
endmodule

// File: rtl/wbuf_issue.sv
module wbuf_issue
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          push,
  input  wentry_t       cur_ent,
  input  wentry_t       nxt_ent,
  input  logic          cmd_ready,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  output logic [PW-1:0] rd_off,
  output logic          cmd_valid,
  output logic          cmd_eop,
  output logic          free,
  output logic [CW-1:0] free_cnt,
  output logic          err_pulse
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} st_t;

  st_t           st_q;
  logic [PW-1:0] off_q;
  logic [CW-1:0] lim_q, blen_q;
  logic          err_q;
  logic          start, fire, beat_last, at_limit;

  assign start     = (st_q == ST_IDLE) && (count != '0) && !push;
  assign fire      = cmd_valid && cmd_ready;
  assign at_limit  = (CW'(off_q) + CW'(1)) == lim_q;
  assign beat_last = at_limit || !joins(cur_ent.addr, nxt_ent.addr);

  assign rd_off    = off_q;
  assign cmd_valid = (st_q == ST_SEND);
  assign cmd_eop   = cmd_valid && beat_last;
  assign free      = (st_q == ST_WAIT) && rsp_valid;
  assign free_cnt  = blen_q;
  assign err_pulse = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      off_q  <= '0;
      lim_q  <= '0;
      blen_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= free && rsp_err;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_SEND;
          off_q <= '0;
          lim_q <= count;
        end
        ST_SEND: if (fire) begin
          if (beat_last) begin
            st_q   <= ST_WAIT;
            blen_q <= CW'(off_q) + CW'(1);
          end else begin
            off_q <= off_q + PW'(1);
          end
        end
        ST_WAIT: if (rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cur_ent) && $stable(cmd_eop)));

  // R8
  no_issue_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_eop) |=> !cmd_valid);

  // R4
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((CW'(off_q) < lim_q) && (lim_q <= count)));
endmodule

// File: rtl/wbuf_coalesce.sv
module wbuf_coalesce
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [BEW-1:0] wr_be,
  output logic           wr_full,
  output logic           buf_empty,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [AW-1:0]  cmd_addr,
  output logic [DW-1:0]  cmd_data,
  output logic [BEW-1:0] cmd_be,
  output logic           cmd_eop,
  input  logic           rsp_valid,
  input  logic           rsp_err,
  output logic           wr_err
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push, free;
  logic [CW-1:0] free_cnt, count;
  logic [PW-1:0] rd_off;
  wentry_t       push_ent, cur_ent, nxt_ent;

  assign wr_full   = (count == CW'(DEPTH));
  assign buf_empty = (count == '0);
  assign push      = wr_valid && !wr_full;
  assign push_ent  = '{addr: wr_addr, data: wr_data, be: wr_be};
  assign cmd_addr  = cur_ent.addr;
  assign cmd_data  = cur_ent.data;
  assign cmd_be    = cur_ent.be;

  wbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent),
    .free(free), .free_cnt(free_cnt), .rd_off(rd_off),
    .cur_ent(cur_ent), .nxt_ent(nxt_ent), .count(count)
  );

  wbuf_issue #(.DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n), .count(count), .push(push),
    .cur_ent(cur_ent), .nxt_ent(nxt_ent), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rd_off(rd_off),
    .cmd_valid(cmd_valid), .cmd_eop(cmd_eop), .free(free),
    .free_cnt(free_cnt), .err_pulse(wr_err)
  );

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> !wr_err);
endmodule

// File: tb/sim_wbuf_coalesce.sv
`timescale 1ns/1ps
module sim_wbuf_coalesce;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_valid = 1'b0, cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        wr_full, buf_empty, cmd_valid, cmd_eop, wr_err;
  logic [31:0] cmd_addr, cmd_data;
  logic [3:0]  cmd_be;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wbuf_coalesce u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_full(wr_full), .buf_empty(buf_empty),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_be(cmd_be), .cmd_eop(cmd_eop),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .wr_err(wr_err)
  );

  // {scenario_end, expected_eop, addr, data, be}
  localparam logic [69:0] VEC [15] = '{
    {1'b0, 1'b0, 32'h0000_0100, 32'hA000_0000, 4'hF},
    {1'b0, 1'b0, 32'h0000_0104, 32'hA000_0001, 4'hF},
    {1'b0, 1'b0, 32'h0000_0108, 32'hA000_0002, 4'hF},
    {1'b0, 1'b1, 32'h0000_010C, 32'hA000_0003, 4'hF},
    {1'b0, 1'b0, 32'h0000_0200, 32'hA000_0004, 4'hF},
    {1'b0, 1'b1, 32'h0000_0204, 32'hA000_0005, 4'hF},
    {1'b0, 1'b0, 32'h0000_0300, 32'hA000_0006, 4'hF},
    {1'b1, 1'b1, 32'h0000_0304, 32'hA000_0007, 4'hF},
    {1'b0, 1'b0, 32'h0000_0040, 32'hB000_0000, 4'hF},
    {1'b0, 1'b0, 32'h0000_0044, 32'hB000_0001, 4'h3},
    {1'b1, 1'b1, 32'h0000_0048, 32'hB000_0002, 4'hC},
    {1'b0, 1'b1, 32'h0000_0080, 32'hC000_0000, 4'hF},
    {1'b0, 1'b1, 32'h0000_0080, 32'hC000_0001, 4'h1},
    {1'b0, 1'b1, 32'h0000_007C, 32'hC000_0002, 4'hF},
    {1'b1, 1'b1, 32'h0000_0084, 32'hC000_0003, 4'hF}
  };

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain(input int lo, input int hi, input bit err);
    int k = lo;
    cmd_ready = 1'b1;
    while (k <= hi) begin
      if (cmd_valid) begin
        // R2 R4 R5: order, contents, mask and end marker of each beat
        chk({cmd_addr, cmd_data, cmd_be, cmd_eop} ==
            {VEC[k][67:36], VEC[k][35:4], VEC[k][3:0], VEC[k][68]},
            "R2/R4/R5 beat", {3'b0, cmd_addr, cmd_data, cmd_be, cmd_eop},
            {3'b0, VEC[k][67:36], VEC[k][35:4], VEC[k][3:0], VEC[k][68]});
        k++;
        if (cmd_eop) begin
          for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            chk(!cmd_valid, "R8 quiet wait", 72'(cmd_valid), 72'd0);
            chk(!buf_empty, "R9 held until rsp", 72'(buf_empty), 72'd0);
            if (k == 4) chk(wr_full, "R9 full until rsp", 72'(wr_full), 72'd1);
          end
          rsp_valid = 1'b1; rsp_err = err;
          @(negedge clk);
          rsp_valid = 1'b0; rsp_err = 1'b0;
          chk(wr_err == err, "R10 err pulse", 72'(wr_err), 72'(err));
          if (k > hi) chk(buf_empty, "R9 empty after rsp", 72'(buf_empty), 72'd1);
          @(negedge clk);
          chk(!wr_err, "R10 single pulse", 72'(wr_err), 72'd0);
        end else begin
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo = 0;
    int scen = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(buf_empty && !wr_full && !cmd_valid && !wr_err, "R1 reset",
        {68'b0, buf_empty, wr_full, cmd_valid, wr_err}, 72'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buf_empty && !cmd_valid, "R1 after release", {70'b0, buf_empty, cmd_valid}, 72'b10);

    // R11: stray response while idle
    rsp_valid = 1'b1; rsp_err = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
    chk(!wr_err && buf_empty && !cmd_valid, "R11 stray rsp",
        {69'b0, wr_err, buf_empty, cmd_valid}, 72'b010);
    @(negedge clk);
    chk(!wr_err, "R11 stray rsp later", 72'(wr_err), 72'd0);

    for (int i = 0; i < 15; i++) begin
      if (i == lo) cmd_ready = (scen != 0);
      put(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]);
      // R6: no burst while writes stream in
      chk(!cmd_valid, "R6 hold while writing", 72'(cmd_valid), 72'd0);
      if (VEC[i][69]) begin
        if (scen == 0) begin
          // R3
          chk(wr_full, "R3 full at eight", 72'(wr_full), 72'd1);
          put(32'h0000_0999, 32'hDEAD_BEEF, 4'hF);
          chk(cmd_valid && wr_full, "R3/R7 stalled burst", {70'b0, cmd_valid, wr_full}, 72'b11);
          @(negedge clk);
          chk(cmd_valid && cmd_addr == 32'h100, "R7 stable under stall",
              {39'b0, cmd_valid, cmd_addr}, {39'b0, 1'b1, 32'h100});
        end else begin
          @(negedge clk);
          chk(cmd_valid, "R6 start after writes stop", 72'(cmd_valid), 72'd1);
        end
        drain(lo, i, scen == 1);
        // R3: dropped write never surfaces
        chk(buf_empty && !cmd_valid, "R3/R9 drained", {70'b0, buf_empty, cmd_valid}, 72'b10);
        lo = i + 1;
        scen++;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule